// File: doc/BRIEF.md
# Byte Shift, Rotate and Bit-Manipulation Unit

This combinational datapath slice performs single-byte rotates (through the carry and circular), left and right shifts (arithmetic and logical), a nibble exchange, and single-bit test, clear and set. The surrounding core supplies an operand byte, the current flag nibble, a bit index and an operation code. The unit returns the new byte, the new flags and a strobe that says whether the byte should be written back. Operand fetch, read-modify-write sequencing against memory and opcode decode stay in the caller.

A separate accumulator input selects the short accumulator rotate forms. In that mode, the four rotate operations force the zero flag low whatever the result is. All other operations ignore the accumulator input.

The flag nibble is packed as {Z, N, H, C}, with Z in bit 3 and C in bit 0. The operation codes are: 0 circular left, 1 circular right, 2 left through carry, 3 right through carry, 4 arithmetic left shift, 5 arithmetic right shift, 6 nibble swap, 7 logical right shift, 8 bit test, 9 bit clear, 10 bit set. Codes 11 to 15 are unused.

Top module: `sbu_top`

## Requirements
- R1: Code 2 shifts the byte left and puts the old C in bit 0 and the old bit 7 in C. Code 3 shifts the byte right and puts the old C in bit 7 and the old bit 0 in C.
- R2: Code 0 copies the old bit 7 into bit 0 and into C. Code 1 copies the old bit 0 into bit 7 and into C.
- R3: Code 4 shifts left, fills bit 0 with 0 and moves the old bit 7 into C.
- R4: Code 5 shifts right, keeps bit 7 and moves the old bit 0 into C. Code 7 shifts right, fills bit 7 with 0 and moves the old bit 0 into C.
- R5: Code 6 exchanges the high and low nibbles, sets Z when the result is zero, and clears N, H and C.
- R6: Codes 0 to 5 and 7 clear N and H. With the accumulator input low, they set Z exactly when the result byte is zero.
- R7: With the accumulator input high, codes 0 to 3 drive Z to 0 and leave result and C as in R1 and R2. For every other code, the accumulator input has no effect on any output.
- R8: Code 8 sets Z when operand bit [index] is 0, clears N, sets H, keeps C, passes the operand to the result, and holds the write enable low.
- R9: Code 9 forces operand bit [index] to 0 and code 10 forces it to 1, where index 0 is the least significant bit. Both leave the other bits and all four flags unchanged.
- R10: Codes 11 to 15 pass the operand and the flags through unchanged, with the write enable low.
- R11: The write enable is high for codes 0 to 7, 9 and 10, and low for all other codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| bit_idx_i | input | 3 | Bit index for codes 8 to 10 |
| op_i | input | 4 | Operation code |
| acc_mode_i | input | 1 | Selects the accumulator rotate flag rule |
| result_o | output | 8 | Result byte |
| flags_o | output | 4 | Outgoing flags {Z,N,H,C} |
| wr_en_o | output | 1 | Write the result back |

## Verification
The bench targets the bit that crosses the byte edge in each rotate and shift. A design that swapped the through-carry and circular forms would return the wrong bit 0 or bit 7 when the carry and the outgoing bit differ. Zero results are checked both with and without the accumulator input: a design that forgot to force Z low would flag a rotate of 0x80 as zero. Bit test is checked at indices 0 and 7 with C set and clear, which catches an inverted Z, a lost C, or a write enable that stays high. The unused codes are checked for an unchanged pass-through, which would expose a default branch that still shifts or writes.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    parameter int unsigned DATA_W = 8;
    localparam int unsigned NIB_W = DATA_W / 2;
    localparam int unsigned IDX_W = $clog2(DATA_W);

    typedef enum logic [3:0] {
        OP_CRL  = 4'd0,
        OP_CRR  = 4'd1,
        OP_TCL  = 4'd2,
        OP_TCR  = 4'd3,
        OP_SHLA = 4'd4,
        OP_SHRA = 4'd5,
        OP_NSWP = 4'd6,
        OP_SHRL = 4'd7,
        OP_BTST = 4'd8,
        OP_BCLR = 4'd9,
        OP_BSET = 4'd10
    } sbu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } sbu_flags_t;

    function automatic logic op_is_rotate(input logic [3:0] op);
        return op <= 4'd3;
    endfunction

    function automatic logic op_is_shifter(input logic [3:0] op);
        return op <= 4'd7;
    endfunction

    function automatic logic op_is_bitwr(input logic [3:0] op);
        return (op == 4'd9) || (op == 4'd10);
    endfunction

endpackage

// File: rtl/sbu_shift_core.sv
module sbu_shift_core
    import sbu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] opnd,
    input  logic         c_in,
    input  logic [3:0]   op,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         hit
);
    localparam int unsigned HALF = W / 2;

    logic msb, lsb;
    assign msb = opnd[W-1];
    assign lsb = opnd[0];

    always_comb begin
        res   = opnd;
        c_out = c_in;
        hit   = 1'b1;
        unique case (op)
            4'd0: begin res = {opnd[W-2:0], msb};   c_out = msb; end
            4'd1: begin res = {lsb, opnd[W-1:1]};   c_out = lsb; end
            4'd2: begin res = {opnd[W-2:0], c_in};  c_out = msb; end
            4'd3: begin res = {c_in, opnd[W-1:1]};  c_out = lsb; end
            4'd4: begin res = {opnd[W-2:0], 1'b0};  c_out = msb; end
            4'd5: begin res = {msb, opnd[W-1:1]};   c_out = lsb; end
            4'd6: begin res = {opnd[HALF-1:0], opnd[W-1:HALF]}; c_out = 1'b0; end
            4'd7: begin res = {1'b0, opnd[W-1:1]};  c_out = lsb; end
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        if (op == 4'd5) begin
            p_sra_keep_msb_r4: assert (res[W-1] == opnd[W-1] && c_out == opnd[0])
                else $error("arithmetic right shift lost sign or carry");
        end
        if (op == 4'd2) begin
            p_tcl_carry_r1: assert (res[0] == c_in && c_out == opnd[W-1])
                else $error("rotate through carry left wrong");
        end
    end

endmodule

// File: rtl/sbu_bit_core.sv
module sbu_bit_core
    import sbu_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned IW = IDX_W
) (
    input  logic [W-1:0]  opnd,
    input  logic [IW-1:0] idx,
    input  logic [3:0]    op,
    output logic [W-1:0]  res,
    output logic          sel_zero
);
    logic [W-1:0] mask;

    for (genvar g = 0; g < W; g++) begin : g_mask
        assign mask[g] = (idx == IW'(g));
    end

    assign sel_zero = ~|(opnd & mask);

    always_comb begin
        res = opnd;
        if (op == 4'd9)       res = opnd & ~mask;
        else if (op == 4'd10) res = opnd | mask;
    end

    always_comb begin
        p_mask_onehot_r9: assert ($onehot(mask))
            else $error("bit index decode not one-hot");
        if (op == 4'd9 || op == 4'd10) begin
            p_other_bits_r9: assert (((res ^ opnd) & ~mask) == '0)
                else $error("bit write touched other bits");
        end
    end

endmodule

// File: rtl/sbu_top.sv
module sbu_top
    import sbu_pkg::*;
(
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [3:0]        flags_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic [3:0]        op_i,
    input  logic              acc_mode_i,
    output logic [DATA_W-1:0] result_o,
    output logic [3:0]        flags_o,
    output logic              wr_en_o
);
    sbu_flags_t fin, fout;
    logic [DATA_W-1:0] sh_res, bt_res;
    logic sh_c, sh_hit, bt_zero;

    assign fin = sbu_flags_t'(flags_i);

    sbu_shift_core #(.W(DATA_W)) u_shift (
        .opnd (opnd_i),
        .c_in (fin.c),
        .op   (op_i),
        .res  (sh_res),
        .c_out(sh_c),
        .hit  (sh_hit)
    );

    sbu_bit_core #(.W(DATA_W), .IW(IDX_W)) u_bit (
        .opnd    (opnd_i),
        .idx     (bit_idx_i),
        .op      (op_i),
        .res     (bt_res),
        .sel_zero(bt_zero)
    );

    always_comb begin
        fout     = fin;
        result_o = opnd_i;
        wr_en_o  = 1'b0;
        if (sh_hit) begin
            result_o = sh_res;
            wr_en_o  = 1'b1;
            fout.n   = 1'b0;
            fout.h   = 1'b0;
            fout.c   = sh_c;
            fout.z   = (sh_res == '0) && !(acc_mode_i && op_is_rotate(op_i));
        end else if (op_i == OP_BTST) begin
            fout.z = bt_zero;
            fout.n = 1'b0;
            fout.h = 1'b1;
        end else if (op_is_bitwr(op_i)) begin
            result_o = bt_res;
            wr_en_o  = 1'b1;
        end
    end

    assign flags_o = fout;

    always_comb begin
        if (op_is_shifter(op_i)) begin
            p_nh_clear_r6: assert (flags_o[2:1] == 2'b00)
                else $error("shift left N/H set");
        end
        if (acc_mode_i && op_is_rotate(op_i)) begin
            p_acc_z_low_r7: assert (flags_o[3] == 1'b0)
                else $error("accumulator rotate set Z");
        end
        if (op_i == 4'd6) begin
            p_swap_c_clear_r5: assert (flags_o[0] == 1'b0)
                else $error("swap left C set");
        end
        if (op_i == 4'd8) begin
            p_btst_nowrite_r8: assert (!wr_en_o && flags_o[0] == flags_i[0] && flags_o[1])
                else $error("bit test flags or write enable wrong");
        end
        if (op_i >= 4'd11) begin
            p_unused_pass_r10: assert (!wr_en_o && result_o == opnd_i && flags_o == flags_i)
                else $error("unused code altered state");
        end
        if (op_is_bitwr(op_i)) begin
            p_bitwr_flags_r9: assert (flags_o == flags_i && wr_en_o)
                else $error("bit write changed flags");
        end
    end

endmodule

// File: tb/sbu_top_bench.sv
module sbu_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 27;

    // {op[32:29], acc[28], idx[27:25], fl_in[24:21], opnd[20:13], res[12:5], fl_out[4:1], we[0]}
    localparam logic [32:0] VEC [NV] = '{
        {4'd2, 1'b0, 3'd0, 4'b0000, 8'h80, 8'h00, 4'b1001, 1'b1}, // R1
        {4'd2, 1'b0, 3'd0, 4'b0001, 8'h01, 8'h03, 4'b0000, 1'b1}, // R1
        {4'd3, 1'b0, 3'd0, 4'b0000, 8'h01, 8'h00, 4'b1001, 1'b1}, // R1
        {4'd3, 1'b0, 3'd0, 4'b0001, 8'h00, 8'h80, 4'b0000, 1'b1}, // R1
        {4'd0, 1'b0, 3'd0, 4'b0000, 8'h85, 8'h0B, 4'b0001, 1'b1}, // R2
        {4'd1, 1'b0, 3'd0, 4'b0000, 8'h01, 8'h80, 4'b0001, 1'b1}, // R2
        {4'd1, 1'b0, 3'd0, 4'b0111, 8'h00, 8'h00, 4'b1000, 1'b1}, // R2 R6
        {4'd4, 1'b0, 3'd0, 4'b0000, 8'hFF, 8'hFE, 4'b0001, 1'b1}, // R3
        {4'd4, 1'b0, 3'd0, 4'b0001, 8'h80, 8'h00, 4'b1001, 1'b1}, // R3
        {4'd5, 1'b0, 3'd0, 4'b0000, 8'h81, 8'hC0, 4'b0001, 1'b1}, // R4
        {4'd5, 1'b0, 3'd0, 4'b1110, 8'h02, 8'h01, 4'b0000, 1'b1}, // R4 R6
        {4'd7, 1'b0, 3'd0, 4'b0000, 8'h81, 8'h40, 4'b0001, 1'b1}, // R4
        {4'd7, 1'b0, 3'd0, 4'b0000, 8'h01, 8'h00, 4'b1001, 1'b1}, // R4
        {4'd6, 1'b0, 3'd0, 4'b0111, 8'h3C, 8'hC3, 4'b0000, 1'b1}, // R5
        {4'd6, 1'b0, 3'd0, 4'b0001, 8'h00, 8'h00, 4'b1000, 1'b1}, // R5
        {4'd2, 1'b1, 3'd0, 4'b0000, 8'h80, 8'h00, 4'b0001, 1'b1}, // R7
        {4'd1, 1'b1, 3'd0, 4'b1000, 8'h00, 8'h00, 4'b0000, 1'b1}, // R7
        {4'd6, 1'b1, 3'd0, 4'b0000, 8'h00, 8'h00, 4'b1000, 1'b1}, // R7
        {4'd8, 1'b0, 3'd3, 4'b0001, 8'h08, 8'h08, 4'b0011, 1'b0}, // R8
        {4'd8, 1'b0, 3'd7, 4'b0100, 8'h7F, 8'h7F, 4'b1010, 1'b0}, // R8
        {4'd8, 1'b0, 3'd0, 4'b1111, 8'hFE, 8'hFE, 4'b1011, 1'b0}, // R8
        {4'd9, 1'b0, 3'd7, 4'b1010, 8'hFF, 8'h7F, 4'b1010, 1'b1}, // R9
        {4'd10,1'b0, 3'd0, 4'b0101, 8'h00, 8'h01, 4'b0101, 1'b1}, // R9
        {4'd10,1'b0, 3'd4, 4'b0000, 8'h10, 8'h10, 4'b0000, 1'b1}, // R9
        {4'd11,1'b0, 3'd2, 4'b1001, 8'h5A, 8'h5A, 4'b1001, 1'b0}, // R10
        {4'd15,1'b1, 3'd5, 4'b0110, 8'hA5, 8'hA5, 4'b0110, 1'b0}, // R10
        {4'd0, 1'b1, 3'd0, 4'b0000, 8'h80, 8'h01, 4'b0001, 1'b1}  // R7
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] opnd;
    logic [3:0] fl_in;
    logic [2:0] idx;
    logic [3:0] op;
    logic acc;
    logic [7:0] res;
    logic [3:0] fl_out;
    logic we;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbu_top u_sbu_top (
        .opnd_i    (opnd),
        .flags_i   (fl_in),
        .bit_idx_i (idx),
        .op_i      (op),
        .acc_mode_i(acc),
        .result_o  (res),
        .flags_o   (fl_out),
        .wr_en_o   (we)
    );

    task automatic apply(input logic [3:0] o, input logic a, input logic [2:0] i,
                         input logic [3:0] f, input logic [7:0] d);
        @(posedge clk);
        #1;
        op = o; acc = a; idx = i; fl_in = f; opnd = d;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] er,
                         input logic [3:0] ef, input logic ew);
        checks++;
        if (res !== er || fl_out !== ef || we !== ew) begin
            errors++;
            $display("FAIL %s op=%0d res=%h/%h flags=%b/%b we=%b/%b (actual/expected)",
                     req, op, res, er, fl_out, ef, we, ew);
        end
    endtask

    initial begin
        op = 4'd12; acc = 1'b0; idx = '0; fl_in = 4'b1010; opnd = 8'h3E;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 initial pass-through", 8'h3E, 4'b1010, 1'b0);

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][32:29], VEC[k][28], VEC[k][27:25], VEC[k][24:21], VEC[k][20:13]);
            check($sformatf("R1-11 table row %0d", k), VEC[k][12:5], VEC[k][4:1], VEC[k][0]);
        end

        // R9: every index, clear and set on alternating patterns
        for (int b = 0; b < 8; b++) begin
            apply(4'd9, 1'b0, 3'(b), 4'b1100, 8'hFF);
            check("R9 clear sweep", 8'hFF & ~(8'h01 << b), 4'b1100, 1'b1);
            apply(4'd10, 1'b1, 3'(b), 4'b0011, 8'h00);
            check("R9 set sweep", 8'h01 << b, 4'b0011, 1'b1);
            apply(4'd8, 1'b0, 3'(b), 4'b0000, 8'h01 << b);
            check("R8 test sweep", 8'h01 << b, 4'b0010, 1'b0);
        end

        // R11: write enable per code
        for (int c = 0; c < 16; c++) begin
            apply(4'(c), 1'b0, 3'd0, 4'b0000, 8'h11);
            checks++;
            if (we !== ((c <= 7) || c == 9 || c == 10)) begin
                errors++;
                $display("FAIL R11 code %0d we=%b expected=%b", c, we,
                         ((c <= 7) || c == 9 || c == 10));
            end
        end

        // R5: swap of 0xF0 gives 0x0F with Z clear
        apply(4'd6, 1'b0, 3'd0, 4'b1111, 8'hF0);
        check("R5 swap F0", 8'h0F, 4'b0000, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule